// File: doc/BRIEF.md
# Indexed Fibonacci term generator

The block produces one Fibonacci term on request. A caller places an unsigned index on the index input and pulses start for one clock. The block then steps a two-term recurrence once per clock. An internal step counter is compared against the captured index. When the two match, the recurrence freezes, and the requested term remains on the result output until the next start or reset.

The seed terms are loaded through a multiplexer on start. The recurrence registers therefore need no preset values, and an index of zero completes immediately with a result of zero. A done flag marks the cycle in which the result becomes final and stays high while the result is held.

Top module: `fib_nth`

## Requirements
- R1: While rst_ni is low, and after its release until the first start, result_o is 0 and done_o is 0.
- R2: After a start pulse sampled at a clock edge with index N (n_i, 4-bit unsigned, 0 to 15), result_o equals term F(k) of the sequence F(0)=0, F(1)=1, F(i)=F(i-1)+F(i-2) after the k-th further edge, for k from 0 to N.
- R3: done_o is low after edges 0 to N-1 that follow the start, and rises after edge N. Its rise coincides with result_o reaching F(N), never F(N-1) or F(N+1).
- R4: Once done_o is high, result_o stays at F(N) and done_o stays high until the next start or reset, for at least 20 cycles.
- R5: With N = 0, done_o is high and result_o is 0 right after the start edge.
- R6: A change on n_i without a start pulse does not alter the sequence or the stopping point of the request in progress.
- R7: A start pulse during a run restarts the computation from the seed terms using the newly presented index.
- R8: result_o is 10 bits wide and represents F(15) = 610 exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request; captures n_i and reloads the seed terms |
| n_i | input | 4 | Requested term index |
| result_o | output | 10 | Current term; final once done_o is high |
| done_o | output | 1 | High while result_o holds the requested term |

## Verification
The assertions assume that start_i is a synchronous pulse and that n_i matters only in a cycle where start_i is high. They make no assumption about the value of n_i on other cycles. The stimulus covers every index from 0 to 15 and holds each result for more than 20 cycles. It also drives a different value onto n_i during a run and starts a new run before the previous one has finished. Reset is asserted only between sample points, so every check sees a settled state.

// File: rtl/fib_nth_pkg.sv
package fib_nth_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } fib_state_e;

  // Term value, used to size the result port
  function automatic int unsigned fib_term(input int unsigned idx);
    int unsigned a, b, t;
    a = 0;
    b = 1;
    for (int unsigned i = 0; i < idx; i++) begin
      t = a + b;
      a = b;
      b = t;
    end
    return a;
  endfunction

  function automatic int unsigned bits_for(input int unsigned v);
    int unsigned w;
    w = 1;
    while ((v >> w) != 0) w++;
    return w;
  endfunction
endpackage

// File: rtl/fib_step_ctrl.sv
module fib_step_ctrl
  import fib_nth_pkg::*;
#(
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IDX_W-1:0] n_i,
  output logic             seed_o,
  output logic             adv_o,
  output logic             done_o
);
  fib_state_e       state_q;
  logic [IDX_W-1:0] n_q, cnt_q;
  logic             hit;

  assign hit    = (cnt_q == n_q);
  assign seed_o = start_i;
  assign adv_o  = (state_q == ST_BUSY) && !hit && !start_i;
  assign done_o = (state_q == ST_BUSY) && hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      n_q     <= '0;
      cnt_q   <= '0;
    end else if (start_i) begin
      state_q <= ST_BUSY;
      n_q     <= n_i;
      cnt_q   <= '0;
    end else if (adv_o) begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/fib_term_regs.sv
module fib_term_regs #(
  parameter int unsigned RES_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             seed_i,
  input  logic             adv_i,
  output logic [RES_W-1:0] cur_o
);
  logic [RES_W-1:0] cur_q, nxt_q, sum, cur_d, nxt_d;
  logic             en;

  assign sum   = cur_q + nxt_q;
  // seed mux replaces preset register contents
  assign cur_d = seed_i ? '0 : nxt_q;
  assign nxt_d = seed_i ? RES_W'(1) : sum;
  assign en    = seed_i | adv_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
      nxt_q <= '0;
    end else if (en) begin
      cur_q <= cur_d;
      nxt_q <= nxt_d;
    end
  end

  assign cur_o = cur_q;
endmodule

// File: rtl/fib_nth.sv
module fib_nth
  import fib_nth_pkg::*;
#(
  parameter int unsigned IDX_W = 4,
  // lookahead term F(max+1) must also fit
  parameter int unsigned RES_W = bits_for(fib_term((1 << IDX_W)))
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IDX_W-1:0] n_i,
  output logic [RES_W-1:0] result_o,
  output logic             done_o
);
  logic seed, adv;

  fib_step_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .n_i    (n_i),
    .seed_o (seed),
    .adv_o  (adv),
    .done_o (done_o)
  );

  fib_term_regs #(.RES_W(RES_W)) u_terms (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .seed_i (seed),
    .adv_i  (adv),
    .cur_o  (result_o)
  );
endmodule

// File: rtl/fib_nth_chk.sv
module fib_nth_chk #(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned RES_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [IDX_W-1:0] n_i,
  input logic [RES_W-1:0] result_o,
  input logic             done_o
);
  logic             seen_q;
  logic [IDX_W-1:0] n_q;
  logic [IDX_W:0]   cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      n_q    <= '0;
      cyc_q  <= '0;
    end else if (start_i) begin
      seen_q <= 1'b1;
      n_q    <= n_i;
      cyc_q  <= '0;
    end else if (!cyc_q[IDX_W]) begin
      cyc_q  <= cyc_q + 1'b1;
    end
  end

  // R1
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> (!done_o && result_o == '0));
  // R3
  done_timing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> (done_o == (cyc_q >= {1'b0, n_q})));
  // R5
  zero_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && n_i == '0) |=> (done_o && result_o == '0));
  // R4
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(result_o)));
  // R7
  reseed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (result_o == '0));
endmodule

bind fib_nth fib_nth_chk #(.IDX_W(IDX_W), .RES_W(RES_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .n_i     (n_i),
  .result_o(result_o),
  .done_o  (done_o)
);

// File: tb/sim_fib_nth.sv
module sim_fib_nth;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] n = '0;
  logic [9:0] res;
  logic       done;
  int         checks = 0;
  int         fails = 0;

  always #2 clk = ~clk;

  fib_nth u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .n_i(n),
    .result_o(res), .done_o(done)
  );

  function automatic int fib(input int k);
    int a = 0, b = 1, t;
    for (int i = 0; i < k; i++) begin t = a + b; a = b; b = t; end
    return a;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // leaves the bench at the negedge after the start edge (k = 0)
  task automatic kick(input int idx);
    @(negedge clk);
    start = 1'b1;
    n = 4'(idx);
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset result", int'(res), 0);
    chk("R1 reset done", int'(done), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 idle result", int'(res), 0);
    chk("R1 idle done", int'(done), 0);

    // R2 R3 R4 R5 R8 exhaustive sweep of the index
    for (int idx = 0; idx < 16; idx++) begin
      kick(idx);
      for (int k = 0; k <= idx + 22; k++) begin
        int kk;
        kk = (k < idx) ? k : idx;
        chk(idx == 0 ? "R5 result" : "R2 result", int'(res), fib(kk));
        chk(k < idx ? "R3 done" : "R4 done", int'(done), (k >= idx) ? 1 : 0);
        @(negedge clk);
      end
    end
    chk("R8 F15", int'(res), 610);

    // R6 index change without start is ignored
    kick(7);
    @(negedge clk);
    n = 4'd2;
    for (int k = 2; k <= 12; k++) begin
      @(negedge clk);
      if (k == 7 || k == 12) begin
        chk("R6 result", int'(res), fib(7));
        chk("R6 done", int'(done), 1);
      end
    end
    n = 4'd9;
    repeat (4) @(negedge clk);
    chk("R6 held", int'(res), fib(7));

    // R7 restart mid-run
    kick(12);
    repeat (4) @(negedge clk);
    chk("R7 mid", int'(res), fib(4));
    kick(5);
    chk("R7 reseed", int'(res), 0);
    repeat (5) @(negedge clk);
    chk("R7 result", int'(res), fib(5));
    chk("R7 done", int'(done), 1);

    // R1 reset mid-run
    kick(15);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid reset result", int'(res), 0);
    chk("R1 mid reset done", int'(done), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 post reset done", int'(done), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule